// File: doc/BRIEF.md
# Timestamped Receive Sample Packetizer

This block sits between an ADC sample interface and a host-bound word stream. The converter delivers one complex sample over two clock cycles: the in-phase half on the cycle that `iq_sel` marks, and the quadrature half on the cycle after it. The block packs each pair into a 32-bit word and groups the words into fixed-length packets. Each packet opens with a four-word header that records the time of the packet's first sample.

The time value comes from a free-running counter that is also driven out on `tx_time`, so the transmit path can schedule against the same clock count. A receive time and a transmit time can therefore be subtracted directly. The counter advances once per interface clock, which is two counts per complex sample. It restarts from zero whenever `enable` rises.

A packet enters the buffer only when the buffer has room for the whole packet. Under backpressure the block drops whole packets and flags the gap in the next header, so every packet on the stream is complete and headers fall only on packet-length boundaries. Pulling `enable` low clears the counter, the pairing state, the buffered samples and the pending headers.

Top module: `rx_ts_packetizer`

## Requirements
- R1: `tx_time` is zero while `enable` is low and rises by one on every clock edge at which `enable` is high. After N enabled edges it reads N.
- R2: A sample is taken as I on an edge where `iq_sel` is high, and as Q on the next edge where `iq_sel` is low. The sample word is {Q[15:0], I[15:0]}, with I in bits 15:0. A Q-cycle with no I before it is ignored.
- R3: Each packet is 256 words. Word 0 is the constant 0xB10C5A17. Word 1 is timestamp bits 31:0, which puts the timestamp at byte offset 4. Word 2 is timestamp bits 63:32. Word 3 holds the flags. Words 4 to 255 are 252 sample words in arrival order.
- R4: A packet's timestamp is the `tx_time` value at the I-edge of its first sample. Packets taken back to back differ by 504.
- R5: `m_sop` is high exactly on word 0 of each packet. Every packet is emitted in full, so headers appear only at stream positions that are multiples of 256 words.
- R6: The output follows a valid/ready handshake. While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_sop` hold their values.
- R7: A packet is accepted only if the sample buffer has room for all 252 of its samples at its first I-edge. Otherwise none of its words are emitted, and the next packet starts on its own boundary with its own timestamp.
- R8: Flags bit 0 (overrun) is 1 in the first accepted packet after one or more dropped packets, and 0 in every other packet. Flags bits 31:1 are 0.
- R9: One edge with `enable` low flushes all buffered words and headers, drops `m_valid` and zeroes `tx_time`. After re-enable, the first word out is the header of a packet stamped from the restarted count.
- R10: While `rst_n` is low at a clock edge, the block is cleared as in R9, whatever the value of `enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, two cycles per complex sample |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run when high; when low, clears all state |
| iq_sel | input | 1 | High on the I half of a sample pair |
| adc_data | input | 16 | Converter data, I or Q depending on `iq_sel` |
| tx_time | output | 64 | Shared sample-clock count used by the transmit path |
| m_data | output | 32 | Output stream word |
| m_valid | output | 1 | Output word is valid |
| m_ready | input | 1 | Downstream accepts the word |
| m_sop | output | 1 | Marks word 0 of a packet |

## Verification
The output word and `m_sop` depend only on state, so a word becomes visible in the cycle after the edge that wrote it. A word counts as transferred at the first edge where `m_valid` and `m_ready` are both high. The stream monitor samples a quarter period before each rising edge. It checks every packet against its own header: sample s of a packet stamped T must read {T+2s+1, T+2s}, because the bench drives `adc_data` with the edge index. The effects of `enable` and reset are due one edge after they are applied, and `tx_time` equals the number of enabled edges so far. The directed tasks therefore sample at the falling edge after the stimulus. Expected timestamps for the stall case (0, then 1512 with the overrun flag) follow from the 504-edge packet period and the buffer capacity.

// File: rtl/rxp_pkg.sv
// Shared constants and types for the receive packetizer.
package rxp_pkg;
    localparam int WORD_W    = 32;
    localparam int SAMP_W    = 16;
    localparam int TS_W      = 64;
    localparam int HDR_WORDS = 4;
    localparam logic [WORD_W-1:0] HDR_MARKER = 32'hB10C_5A17;

    // One pending packet header: overrun flag and first-sample time.
    typedef struct packed {
        logic            ovr;
        logic [TS_W-1:0] ts;
    } hdr_t;
endpackage

// File: rtl/rxp_fifo.sv
// Synchronous FIFO with flush and a combinational head read.
// Assumes DEPTH is a power of two. A push when full or a pop when empty is ignored.
module rxp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     push,
    input  logic [W-1:0]             wdata,
    input  logic                     pop,
    output logic [W-1:0]             rdata,
    output logic                     empty,
    output logic [$clog2(DEPTH):0]   level
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign do_push = push && (cnt != (AW+1)'(DEPTH));
    assign do_pop  = pop && (cnt != '0);
    assign rdata   = mem[rp];
    assign empty   = (cnt == '0);
    assign level   = cnt;

    // Pointer and occupancy update; a flush empties the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end
endmodule

// File: rtl/rxp_time_base.sv
// Shared sample-clock counter: cleared while disabled, +1 per enabled edge.
// Assumes a 64-bit count never wraps in practice.
module rxp_time_base (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    output logic [rxp_pkg::TS_W-1:0] now
);
    // Count enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) now <= '0;
        else                   now <= now + 1'b1;
    end
endmodule

// File: rtl/rxp_capture.sv
// Pairs I/Q halves into sample words and decides, at each packet's first
// I-edge, whether the whole packet fits in the buffer. Assumes iq_sel
// alternates; a second I mark before a Q is ignored.
module rxp_capture #(
    parameter int SPP      = 252,
    parameter int DEPTH    = 256,
    parameter int HQ_DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           enable,
    input  logic                           iq_sel,
    input  logic [rxp_pkg::SAMP_W-1:0]     adc_data,
    input  logic [rxp_pkg::TS_W-1:0]       now,
    input  logic [$clog2(DEPTH):0]         sf_level,
    input  logic [$clog2(HQ_DEPTH):0]      hq_level,
    output logic                           s_push,
    output logic [rxp_pkg::WORD_W-1:0]     s_word,
    output logic                           h_push,
    output rxp_pkg::hdr_t                  h_entry
);
    localparam int IW = $clog2(SPP);

    logic                       have_i;
    logic [rxp_pkg::SAMP_W-1:0] i_hold;
    logic [IW-1:0]              idx;
    logic                       keep;
    logic                       pend_ovr;
    logic                       room;
    logic                       start;

    assign room    = ((DEPTH - int'(sf_level)) >= SPP) && (int'(hq_level) < HQ_DEPTH);
    assign start   = enable && iq_sel && !have_i && (idx == '0);
    assign h_push  = start && room;
    assign h_entry = '{ovr: pend_ovr, ts: now};
    assign s_push  = enable && !iq_sel && have_i && keep;
    assign s_word  = {adc_data, i_hold};

    // Pairing, in-packet sample index and accept/drop decision.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            have_i   <= 1'b0;
            i_hold   <= '0;
            idx      <= '0;
            keep     <= 1'b0;
            pend_ovr <= 1'b0;
        end else if (iq_sel) begin
            if (!have_i) begin
                have_i <= 1'b1;
                i_hold <= adc_data;
                if (idx == '0) begin
                    keep     <= room;
                    pend_ovr <= !room;
                end
            end
        end else if (have_i) begin
            have_i <= 1'b0;
            idx    <= (idx == IW'(SPP-1)) ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/rxp_emitter.sv
// Sends each packet as four header words built from the header queue head,
// then the sample words from the sample FIFO. Outputs depend only on state.
module rxp_emitter #(
    parameter int PKT_WORDS = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       hq_empty,
    input  rxp_pkg::hdr_t              hq_head,
    input  logic                       sf_empty,
    input  logic [rxp_pkg::WORD_W-1:0] sf_head,
    input  logic                       m_ready,
    output logic                       m_valid,
    output logic                       m_sop,
    output logic [rxp_pkg::WORD_W-1:0] m_data,
    output logic                       hq_pop,
    output logic                       sf_pop
);
    localparam int WW = $clog2(PKT_WORDS);

    logic [WW-1:0] widx;
    logic          in_hdr, last, fire;

    assign in_hdr  = (widx < WW'(rxp_pkg::HDR_WORDS));
    assign last    = (widx == WW'(PKT_WORDS-1));
    assign m_valid = !hq_empty && (in_hdr || !sf_empty);
    assign m_sop   = m_valid && (widx == '0);
    assign fire    = m_valid && m_ready;
    assign sf_pop  = fire && !in_hdr;
    assign hq_pop  = fire && last;

    // Select the word for the current packet position.
    always_comb begin
        if (widx == WW'(0))      m_data = rxp_pkg::HDR_MARKER;
        else if (widx == WW'(1)) m_data = hq_head.ts[31:0];
        else if (widx == WW'(2)) m_data = hq_head.ts[63:32];
        else if (widx == WW'(3)) m_data = {31'd0, hq_head.ovr};
        else                     m_data = sf_head;
    end

    // Packet position advances on each transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) widx <= '0;
        else if (fire)       widx <= last ? '0 : widx + 1'b1;
    end
endmodule

// File: rtl/rx_ts_packetizer.sv
// Top level: shared time base, I/Q capture with whole-packet admission,
// sample FIFO, header queue and packet emitter. enable low flushes everything.
module rx_ts_packetizer #(
    parameter int PKT_WORDS  = 256,
    parameter int FIFO_DEPTH = 256,
    parameter int HQ_DEPTH   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        iq_sel,
    input  logic [15:0] adc_data,
    output logic [63:0] tx_time,
    output logic [31:0] m_data,
    output logic        m_valid,
    input  logic        m_ready,
    output logic        m_sop
);
    import rxp_pkg::*;

    localparam int SPP = PKT_WORDS - HDR_WORDS;
    localparam int SLW = $clog2(FIFO_DEPTH) + 1;
    localparam int HLW = $clog2(HQ_DEPTH) + 1;

    logic              flush;
    logic              sf_push, sf_pop, sf_empty, sf_full;
    logic [WORD_W-1:0] sf_wdata, sf_head;
    logic [SLW-1:0]    sf_level;
    logic              hq_push, hq_pop, hq_empty;
    hdr_t              hq_wdata, hq_head;
    logic [HLW-1:0]    hq_level;

    assign flush   = !enable;
    assign sf_full = (sf_level == SLW'(FIFO_DEPTH));

    rxp_time_base u_time (
        .clk(clk), .rst_n(rst_n), .enable(enable), .now(tx_time)
    );

    rxp_capture #(.SPP(SPP), .DEPTH(FIFO_DEPTH), .HQ_DEPTH(HQ_DEPTH)) u_cap (
        .clk(clk), .rst_n(rst_n), .enable(enable), .iq_sel(iq_sel),
        .adc_data(adc_data), .now(tx_time), .sf_level(sf_level),
        .hq_level(hq_level), .s_push(sf_push), .s_word(sf_wdata),
        .h_push(hq_push), .h_entry(hq_wdata)
    );

    rxp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_sfifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(sf_push),
        .wdata(sf_wdata), .pop(sf_pop), .rdata(sf_head),
        .empty(sf_empty), .level(sf_level)
    );

    rxp_fifo #(.W($bits(hdr_t)), .DEPTH(HQ_DEPTH)) u_hq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(hq_push),
        .wdata(hq_wdata), .pop(hq_pop), .rdata(hq_head),
        .empty(hq_empty), .level(hq_level)
    );

    rxp_emitter #(.PKT_WORDS(PKT_WORDS)) u_emit (
        .clk(clk), .rst_n(rst_n), .flush(flush), .hq_empty(hq_empty),
        .hq_head(hq_head), .sf_empty(sf_empty), .sf_head(sf_head),
        .m_ready(m_ready), .m_valid(m_valid), .m_sop(m_sop),
        .m_data(m_data), .hq_pop(hq_pop), .sf_pop(sf_pop)
    );
endmodule

// File: rtl/rxp_checker.sv
// Protocol and timing properties of rx_ts_packetizer, attached by bind.
// Keeps its own count of transferred words to locate packet starts.
module rxp_checker #(
    parameter int PKT_WORDS = 256
) (
    input logic        clk,
    input logic        rst_n,
    input logic        enable,
    input logic [63:0] tx_time,
    input logic [31:0] m_data,
    input logic        m_valid,
    input logic        m_ready,
    input logic        m_sop,
    input logic        sf_full,
    input logic        sf_push
);
    localparam int WW = $clog2(PKT_WORDS);
    logic [WW-1:0] hs_cnt;

    // Words transferred within the current packet.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)        hs_cnt <= '0;
        else if (m_valid && m_ready)  hs_cnt <= (hs_cnt == WW'(PKT_WORDS-1)) ? '0 : hs_cnt + 1'b1;
    end

    assert_time_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && $past(rst_n)) |-> (tx_time == $past(tx_time) + 64'd1));

    assert_sop_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (m_sop == (hs_cnt == '0)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready && enable) |=> (m_valid && $stable(m_data) && $stable(m_sop)));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sf_full |-> !sf_push);

    assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!m_valid && (tx_time == 64'd0)));
endmodule

bind rx_ts_packetizer rxp_checker #(.PKT_WORDS(PKT_WORDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tx_time(tx_time),
    .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready), .m_sop(m_sop),
    .sf_full(sf_full), .sf_push(sf_push)
);

// File: tb/rx_ts_packetizer_tb_top.sv
// Directed bench: adc_data carries the edge index, so every sample word is
// predictable from its packet's timestamp.
module rx_ts_packetizer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PKT        = 256;
    localparam int SPP        = 252;
    localparam int PERIOD     = 2 * SPP;
    localparam logic [31:0] MARK = 32'hB10C5A17;

    logic        clk = 1'b0, rst_n = 1'b0, enable = 1'b0, iq_sel = 1'b0, m_ready = 1'b0;
    logic [15:0] adc_data = '0;
    logic [63:0] tx_time;
    logic [31:0] m_data;
    logic        m_valid, m_sop;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_ts_packetizer dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .iq_sel(iq_sel),
        .adc_data(adc_data), .tx_time(tx_time), .m_data(m_data),
        .m_valid(m_valid), .m_ready(m_ready), .m_sop(m_sop)
    );

    int checks = 0, fails = 0, e = 0, ph = 0;

    // Stream monitor state: per-packet timestamp, flags and a content-error bit.
    logic [63:0] p_ts [16];
    logic        p_flag [16];
    logic        p_bad [16];
    int          n_pkts = 0, widx = 0, pos;
    logic [63:0] cur_ts, ev;
    logic        cur_flag, cur_bad;
    logic [15:0] lo;

    // Samples each transfer a quarter period before the rising edge.
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (!rst_n || !enable) widx = 0;
        else if (m_valid && m_ready) begin
            pos = widx % PKT;
            if (pos == 0) cur_bad = 1'b0;
            if (m_sop != (pos == 0)) cur_bad = 1'b1;
            if (pos == 0) begin
                if (m_data != MARK) cur_bad = 1'b1;
            end else if (pos == 1) cur_ts[31:0] = m_data;
            else if (pos == 2) cur_ts[63:32] = m_data;
            else if (pos == 3) begin
                cur_flag = m_data[0];
                if (m_data[31:1] != '0) cur_bad = 1'b1;
            end else begin
                ev = cur_ts + 64'(2 * (pos - 4));
                lo = ev[15:0];
                if (m_data != {lo + 16'd1, lo}) cur_bad = 1'b1;
            end
            if (pos == PKT - 1 && n_pkts < 16) begin
                p_ts[n_pkts]   = cur_ts;
                p_flag[n_pkts] = cur_flag;
                p_bad[n_pkts]  = cur_bad;
                n_pkts++;
            end
            widx++;
        end
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Drive n edges; I on edges whose parity matches ph.
    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            adc_data = e[15:0];
            iq_sel   = ((e % 2) == ph);
            @(negedge clk);
            e++;
        end
    endtask

    task automatic start(int p);
        enable = 1'b1;
        e      = 0;
        ph     = p;
    endtask

    task automatic stop_en();
        enable = 1'b0;
        iq_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_pkt(string req, int i, logic [63:0] ts, logic flag);
        check({req, " timestamp"}, p_ts[i], ts);
        check({req, " flags"}, 64'(p_flag[i]), 64'(flag));
        check({req, " content"}, 64'(p_bad[i]), 64'd0);
    endtask

    task automatic t_reset();
        enable = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 valid in reset", 64'(m_valid), 64'd0);
        check("R10 time in reset", tx_time, 64'd0);
        enable = 1'b0;
        rst_n  = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_stream();
        n_pkts = 0;
        m_ready = 1'b1;
        start(0);
        step(3 * PERIOD + 40);
        check("R1 time count", tx_time, 64'(3 * PERIOD + 40));
        check("R5 packets seen", 64'(n_pkts >= 3), 64'd1);
        check_pkt("R4 R3 R2 pkt0", 0, 64'd0, 1'b0);
        check_pkt("R4 R3 pkt1", 1, 64'(PERIOD), 1'b0);
        check_pkt("R4 R8 pkt2", 2, 64'(2 * PERIOD), 1'b0);
    endtask

    task automatic t_stall();
        stop_en();
        n_pkts = 0;
        m_ready = 1'b0;
        start(0);
        step(10);
        check("R6 valid while stalled", 64'(m_valid), 64'd1);
        check("R5 sop on header", 64'(m_sop), 64'd1);
        check("R3 marker word", 64'(m_data), 64'(MARK));
        step(1090);
        check("R6 data held", 64'(m_data), 64'(MARK));
        m_ready = 1'b1;
        step(1000);
        check("R7 packet count", 64'(n_pkts), 64'd2);
        check_pkt("R7 first", 0, 64'd0, 1'b0);
        check_pkt("R8 after drop", 1, 64'(3 * PERIOD), 1'b1);
    endtask

    task automatic t_flush();
        stop_en();
        n_pkts = 0;
        m_ready = 1'b0;
        start(0);
        step(300);
        check("R9 buffered before disable", 64'(m_valid), 64'd1);
        stop_en();
        check("R9 valid flushed", 64'(m_valid), 64'd0);
        check("R9 time cleared", tx_time, 64'd0);
        m_ready = 1'b1;
        start(1);
        step(520);
        check("R9 one fresh packet", 64'(n_pkts), 64'd1);
        check_pkt("R2 Q-first ignored", 0, 64'd1, 1'b0);
        check("R1 time after re-enable", tx_time, 64'd520);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_stream();
        t_stall();
        t_flush();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule